// File: doc/BRIEF.md
# Burst Address Sequencer

This block keeps the start address of a four-word burst in a register and presents the current word address on every cycle. Two active-low load strobes capture a new start address. The first strobe always loads. The second strobe loads only while the active-low chip enable is low. An active-low advance input moves the burst one word forward, and holding it high keeps the same word address.

The upper address bits pass from the register to the output unchanged. Only the low bits of the address move through the burst. A static order select chooses between two orders. The interleaved order is the start value XOR the burst count. The linear order is the start value plus the count, modulo the burst length. After the last word the address returns to the start value and the same order repeats.

The output is formed combinationally from the registered start bits and the registered count. The word at the start address is therefore presented in the cycle that follows the loading edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, and directly after it, the word address is all zeros.
- R2: When the controller strobe is low at a rising edge, the full input address is captured, whatever the chip enable does. From the next cycle the word address equals the captured address.
- R3: The processor strobe loads the address only when the chip enable is also low at the same edge. If the chip enable is high, that strobe is ignored and the word address stays unchanged.
- R4: When no load occurs and the advance input is high at an edge, the word address holds its value.
- R5: The bits above the low LW bits always equal the loaded upper bits and never change during a burst.
- R6: With order select 1 (interleaved), the low bits equal the start low bits XOR the count of advances since the load.
- R7: With order select 0 (linear), the low bits equal the start low bits plus the advance count, modulo 2^LW.
- R8: After 2^LW advances the word address is the start address again, and further advances repeat the same order.
- R9: A load at the same edge as an advance wins over the advance, and the burst count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | Start address to be captured |
| ctl_strobe_n | input | 1 | Controller load strobe, active low, not gated |
| proc_strobe_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Active-low chip enable that gates the processor strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_xor | input | 1 | Static order select: 1 interleaved, 0 linear |
| word_addr | output | AW | Current word address |

## Verification
The bench builds the block with AW = 8 and LW = 2. This keeps the address small enough to cover every one of the four start values in both burst orders, each under several upper-bit patterns. Each burst runs past its wrap point with suspend cycles placed inside it, so the hold, wrap and load-over-advance cases all occur for every start value. The gated strobe is exercised with the chip enable both high and low against each loaded burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_ADVANCE = 2'd2
    } seq_action_e;

endpackage

// File: rtl/seq_load_decode.sv
module seq_load_decode
    import burst_seq_pkg::*;
(
    input  logic        ctl_strobe_n,
    input  logic        proc_strobe_n,
    input  logic        chip_en_n,
    input  logic        advance_n,
    output seq_action_e action
);

    logic load_req;

    always_comb begin
        load_req = !ctl_strobe_n || (!proc_strobe_n && !chip_en_n);
        if (load_req) begin
            action = ACT_LOAD;
        end else if (!advance_n) begin
            action = ACT_ADVANCE;
        end else begin
            action = ACT_IDLE;
        end
    end

endmodule

// File: rtl/seq_low_map.sv
module seq_low_map
    import burst_seq_pkg::*;
#(
    parameter int LW = 2
) (
    input  logic [LW-1:0] start_low,
    input  logic [LW-1:0] count,
    input  logic          order_xor,
    output logic [LW-1:0] low_out
);

    logic [LW-1:0] xor_low;
    logic [LW-1:0] lin_low;

    always_comb begin
        xor_low = start_low ^ count;
        lin_low = start_low + count;
        if (burst_order_e'(order_xor) == ORDER_XOR) begin
            low_out = xor_low;
        end else begin
            low_out = lin_low;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 19,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          ctl_strobe_n,
    input  logic          proc_strobe_n,
    input  logic          chip_en_n,
    input  logic          advance_n,
    input  logic          order_xor,
    output logic [AW-1:0] word_addr
);

    localparam int UW = AW - LW;

    typedef struct packed {
        logic [UW-1:0] upper;
        logic [LW-1:0] start_low;
        logic [LW-1:0] count;
    } seq_state_t;

    seq_state_t    state_d;
    seq_state_t    state_q;
    seq_action_e   action;
    logic [LW-1:0] low_now;

    seq_load_decode u_decode (
        .ctl_strobe_n (ctl_strobe_n),
        .proc_strobe_n(proc_strobe_n),
        .chip_en_n    (chip_en_n),
        .advance_n    (advance_n),
        .action       (action)
    );

    seq_low_map #(.LW(LW)) u_map (
        .start_low(state_q.start_low),
        .count    (state_q.count),
        .order_xor(order_xor),
        .low_out  (low_now)
    );

    always_comb begin
        state_d = state_q;
        case (action)
            ACT_LOAD: begin
                state_d.upper     = addr_in[AW-1:LW];
                state_d.start_low = addr_in[LW-1:0];
                state_d.count     = '0;
            end
            ACT_ADVANCE: begin
                state_d.count = state_q.count + 1'b1;
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_addr = {state_q.upper, low_now};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int AW = 19,
    parameter int LW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          ctl_strobe_n,
    input logic          proc_strobe_n,
    input logic          chip_en_n,
    input logic          advance_n,
    input logic          order_xor,
    input logic [AW-1:0] word_addr
);

    logic any_load;
    assign any_load = !ctl_strobe_n || (!proc_strobe_n && !chip_en_n);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (word_addr == '0); // R1
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        any_load |=> word_addr == $past(addr_in)); // R9

    AST_CTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_strobe_n |=> word_addr == $past(addr_in)); // R2

    AST_GATED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe_n && !proc_strobe_n && chip_en_n && advance_n) |=> $stable(word_addr)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && advance_n) |=> $stable(word_addr)); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(word_addr[AW-1:LW])); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && !advance_n && !order_xor) |=>
        word_addr[LW-1:0] == LW'($past(word_addr[LW-1:0]) + 1'b1)); // R7

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .ctl_strobe_n (ctl_strobe_n),
    .proc_strobe_n(proc_strobe_n),
    .chip_en_n    (chip_en_n),
    .advance_n    (advance_n),
    .order_xor    (order_xor),
    .word_addr    (word_addr)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int AW = 8;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ctl_strobe_n = 1'b1;
    logic          proc_strobe_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          advance_n = 1'b1;
    logic          order_xor = 1'b0;
    logic [AW-1:0] word_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-LW-1:0] m_up = '0;
    logic [LW-1:0]    m_st = '0;
    logic [LW-1:0]    m_cnt = '0;

    always #5 clk = ~clk;

    burst_addr_seq #(.AW(AW), .LW(LW)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ctl_strobe_n(ctl_strobe_n), .proc_strobe_n(proc_strobe_n),
        .chip_en_n(chip_en_n), .advance_n(advance_n),
        .order_xor(order_xor), .word_addr(word_addr)
    );

    function automatic logic [AW-1:0] expected();
        logic [LW-1:0] lo;
        lo = order_xor ? (m_st ^ m_cnt) : LW'(m_st + m_cnt);
        return {m_up, lo};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (word_addr !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, word_addr, exp);
        end
    endtask

    task automatic tick(input logic c, input logic p, input logic e, input logic a,
                        input logic [AW-1:0] ad, input string tag);
        @(negedge clk);
        ctl_strobe_n = c; proc_strobe_n = p; chip_en_n = e; advance_n = a; addr_in = ad;
        @(posedge clk);
        if (!c || (!p && !e)) begin
            m_up = ad[AW-1:LW]; m_st = ad[LW-1:0]; m_cnt = '0;
        end else if (!a) begin
            m_cnt = m_cnt + 1'b1;
        end
        #1;
        check(tag, expected());
    endtask

    initial begin
        #5000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #23;
        check("R1 reset held", '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", '0);
        for (int ord = 0; ord < 2; ord++) begin
            order_xor = ord[0];
            for (int up = 0; up < 64; up += 21) begin
                for (int st = 0; st < 4; st++) begin
                    logic [AW-1:0] a;
                    logic [AW-1:0] other;
                    a = {6'(up), 2'(st)};
                    other = ~a;
                    // R2: ungated strobe loads even with chip enable high
                    tick(1'b0, 1'b1, 1'b1, 1'b1, a, "R2 ctl load");
                    // R6/R7 steps, R4 hold, R8 wrap after four advances
                    tick(1'b1, 1'b1, 1'b1, 1'b0, other, ord ? "R6 step" : "R7 step");
                    tick(1'b1, 1'b1, 1'b1, 1'b1, other, "R4 hold");
                    tick(1'b1, 1'b1, 1'b1, 1'b0, other, ord ? "R6 step" : "R7 step");
                    tick(1'b1, 1'b1, 1'b1, 1'b0, other, ord ? "R6 step" : "R7 step");
                    tick(1'b1, 1'b1, 1'b1, 1'b0, other, "R8 wrap");
                    check("R8 back at start", a);
                    tick(1'b1, 1'b1, 1'b1, 1'b0, other, "R8 repeat");
                    // R3: gated strobe with chip enable high is ignored
                    tick(1'b1, 1'b0, 1'b1, 1'b1, other, "R3 ignored");
                    // R5: upper bits unchanged during burst
                    checks++;
                    if (word_addr[AW-1:LW] !== a[AW-1:LW]) begin
                        errors++;
                        $display("FAIL R5 actual=%h expected=%h", word_addr[AW-1:LW], a[AW-1:LW]);
                    end
                    // R3: gated strobe with chip enable low loads
                    tick(1'b1, 1'b0, 1'b0, 1'b1, other, "R3 gated load");
                    // R9: load together with advance restarts at count zero
                    tick(1'b1, 1'b1, 1'b1, 1'b0, a, "R9 pre-step");
                    tick(1'b0, 1'b1, 1'b1, 1'b0, a, "R9 load wins");
                    check("R9 at start", a);
                end
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule